// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the already-filtered clock and data lines of a two-wire bus and reports protocol timeouts to the bus controller. It contains two detectors, and each is switched on by its own enable. Both share one sticky timeout flag.

Detector A has two modes, chosen by a mode bit:
- **Clock-low watchdog:** it trips when SCL stays low without a break for (limit+1) × `LOW_SCALE` kernel cycles.
- **Idle sensor:** it trips when SCL and SDA have both been high for (limit+1) × `IDLE_SCALE` kernel cycles.

Detector B adds up the kernel cycles in which SCL is low while the controller marks a clock-extension window. It trips once that total reaches (limit+1) × `LOW_SCALE`. Its total is cleared at every START and STOP that the controller reports.

Configuration is loaded with a write strobe. A detector accepts a new configuration only while that detector is disabled. The flag stays set until the controller writes a clear or disables the peripheral. Each time the flag rises, a one-cycle pulse goes to the controller.

Top module: `smbus_timeout_monitor`

## Requirements
- R1: After reset, `timeoutFlag` and `timeoutPulse` are 0.
- R2: When detector A is in clock-low mode (`detAIdleSel`=0), `timeoutFlag` is 1 after the L-th consecutive clock edge with `sclIn`=0, where L = (`detALimit`+1) × `LOW_SCALE`. A single cycle with `sclIn`=1 restarts the count.
- R3: When detector A is in idle mode (`detAIdleSel`=1), `timeoutFlag` is 1 after the L-th consecutive edge with both `sclIn` and `sdaIn` at 1, where L = (`detALimit`+1) × `IDLE_SCALE`. A single cycle with either line at 0 restarts the count.
- R4: Detector B counts only the edges at which `sclIn`=0 and `extWindow`=1. The count is kept across cycles with `sclIn` high or `extWindow` low. `timeoutFlag` is 1 after the counted edge number (`detBLimit`+1) × `LOW_SCALE`.
- R5: A cycle with `xferStart`=1 or `xferStop`=1 sets detector B's count to zero.
- R6: A detector whose enable is 0 never sets the flag. One cycle with its enable at 0 discards its partial count.
- R7: A configuration write (`detACfgWr` or `detBCfgWr`) is ignored while that detector's enable is 1.
- R8: `timeoutFlag` stays set until `flagClr`=1. If a detector trips in the same cycle as a clear, the flag is still set.
- R9: `periphEn`=0 clears `timeoutFlag` and the counts of both detectors.
- R10: `timeoutPulse` is high for exactly one cycle, in the cycle where `timeoutFlag` first reads 1. A detector that trips while the flag is already 1 produces no pulse.
- R11: Counters saturate instead of wrapping. A detector trips at most once per continuous episode, no matter how long the condition lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periphEn | input | 1 | Peripheral enable; 0 clears the flag and all counts |
| sclIn | input | 1 | Filtered SCL level |
| sdaIn | input | 1 | Filtered SDA level |
| xferStart | input | 1 | One-cycle pulse: START seen |
| xferStop | input | 1 | One-cycle pulse: STOP seen |
| extWindow | input | 1 | High while SCL-low time counts as clock extension |
| detAEn | input | 1 | Detector A enable |
| detAIdleSel | input | 1 | Mode to load into A: 0 clock-low, 1 idle |
| detALimit | input | THRESH_W | Threshold to load into A |
| detACfgWr | input | 1 | Load strobe for A's mode and threshold |
| detBEn | input | 1 | Detector B enable |
| detBLimit | input | THRESH_W | Threshold to load into B |
| detBCfgWr | input | 1 | Load strobe for B's threshold |
| flagClr | input | 1 | Clears the sticky flag |
| timeoutFlag | output | 1 | Sticky timeout flag |
| timeoutPulse | output | 1 | One-cycle pulse when the flag rises |

## Verification
Some rules are checked by assertions on every cycle:
- A counter returns to zero after a clear, holds while idle and never wraps.
- A rising flag always comes with a single pulse.
- The flag stays set until a clear, and disabling the peripheral drops it.
- A threshold does not change while its detector is enabled.

Other behaviour can only be shown by the bench scenarios, because it depends on line patterns:
- The exact trip cycle for every threshold in both A modes and in B.
- B's counting across gaps in SCL-low and in the extension window.
- The restart of a count on a line toggle or on START/STOP.
- The case where a trip and a clear fall in the same cycle.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  // Strobes from control to datapath, one set per kernel cycle.
  typedef struct packed {
    logic aInc;
    logic aClr;
    logic bInc;
    logic bClr;
    logic aLoad;
    logic bLoad;
  } tmoStrobe_t;
endpackage

// File: rtl/tmo_sat_counter.sv
module tmo_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      count <= '0;
    else if (clr)                   count <= '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end

  // A trip happens only on the step into the limit, so it fires once per episode.
  assign hit = inc & ~clr & (count == limit - 1'b1);

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (count == '0));
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!inc && !clr) |=> $stable(count));
  assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !clr && count == CNT_MAX) |=> (count == CNT_MAX));
endmodule

// File: rtl/tmo_datapath.sv
module tmo_datapath
  import tmo_pkg::*;
#(
  parameter int THRESH_W   = 12,
  parameter int LOW_SCALE  = 2048,
  parameter int IDLE_SCALE = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmoStrobe_t          strobe,
  input  logic [THRESH_W-1:0] aLimitIn,
  input  logic                aIdleIn,
  input  logic [THRESH_W-1:0] bLimitIn,
  output logic                aIdleQ,
  output logic [THRESH_W-1:0] aThreshQ,
  output logic [THRESH_W-1:0] bThreshQ,
  output logic                aHit,
  output logic                bHit
);
  localparam int MAX_SCALE = (LOW_SCALE > IDLE_SCALE) ? LOW_SCALE : IDLE_SCALE;
  localparam int CNT_W     = THRESH_W + $clog2(MAX_SCALE) + 1;
  localparam int NUM_DET   = 2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aThreshQ <= '0;
      aIdleQ   <= 1'b0;
      bThreshQ <= '0;
    end else begin
      if (strobe.aLoad) begin
        aThreshQ <= aLimitIn;
        aIdleQ   <= aIdleIn;
      end
      if (strobe.bLoad) bThreshQ <= bLimitIn;
    end
  end

  logic [CNT_W-1:0] aSpan, bSpan;
  logic [CNT_W-1:0] limV [NUM_DET];
  logic [CNT_W-1:0] cntV [NUM_DET];
  logic [NUM_DET-1:0] incV, clrV, hitV;

  assign aSpan   = CNT_W'(aThreshQ) + CNT_W'(1);
  assign bSpan   = CNT_W'(bThreshQ) + CNT_W'(1);
  assign limV[0] = aIdleQ ? aSpan * CNT_W'(IDLE_SCALE) : aSpan * CNT_W'(LOW_SCALE);
  assign limV[1] = bSpan * CNT_W'(LOW_SCALE);
  assign incV    = {strobe.bInc, strobe.aInc};
  assign clrV    = {strobe.bClr, strobe.aClr};

  for (genvar i = 0; i < NUM_DET; i++) begin : g_det
    tmo_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .inc   (incV[i]),
      .clr   (clrV[i]),
      .limit (limV[i]),
      .count (cntV[i]),
      .hit   (hitV[i])
    );
  end

  assign aHit = hitV[0];
  assign bHit = hitV[1];
endmodule

// File: rtl/tmo_control.sv
module tmo_control
  import tmo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       periphEn,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       xferStart,
  input  logic       xferStop,
  input  logic       extWindow,
  input  logic       detAEn,
  input  logic       detBEn,
  input  logic       detACfgWr,
  input  logic       detBCfgWr,
  input  logic       flagClr,
  input  logic       aIdleQ,
  input  logic       aHit,
  input  logic       bHit,
  output tmoStrobe_t strobe,
  output logic       timeoutFlag,
  output logic       timeoutPulse
);
  logic aCond, fire;

  always_comb begin
    aCond        = aIdleQ ? (sclIn & sdaIn) : ~sclIn;
    strobe.aInc  = periphEn & detAEn & aCond;
    strobe.aClr  = ~strobe.aInc;
    strobe.bInc  = periphEn & detBEn & extWindow & ~sclIn;
    strobe.bClr  = ~periphEn | ~detBEn | xferStart | xferStop;
    strobe.aLoad = detACfgWr & ~detAEn;
    strobe.bLoad = detBCfgWr & ~detBEn;
    fire         = aHit | bHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutFlag  <= 1'b0;
      timeoutPulse <= 1'b0;
    end else if (!periphEn) begin
      timeoutFlag  <= 1'b0;
      timeoutPulse <= 1'b0;
    end else begin
      timeoutFlag  <= fire | (timeoutFlag & ~flagClr);
      timeoutPulse <= fire & ~timeoutFlag;
    end
  end

  assert_rise_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> timeoutPulse);
  assert_pulse_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> timeoutFlag);
  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !flagClr && periphEn) |=> timeoutFlag);
  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !periphEn |=> !timeoutFlag);
endmodule

// File: rtl/smbus_timeout_monitor.sv
module smbus_timeout_monitor
  import tmo_pkg::*;
#(
  parameter int THRESH_W   = 12,
  parameter int LOW_SCALE  = 2048,
  parameter int IDLE_SCALE = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                periphEn,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic                xferStart,
  input  logic                xferStop,
  input  logic                extWindow,
  input  logic                detAEn,
  input  logic                detAIdleSel,
  input  logic [THRESH_W-1:0] detALimit,
  input  logic                detACfgWr,
  input  logic                detBEn,
  input  logic [THRESH_W-1:0] detBLimit,
  input  logic                detBCfgWr,
  input  logic                flagClr,
  output logic                timeoutFlag,
  output logic                timeoutPulse
);
  tmoStrobe_t strobe;
  logic aIdleQ, aHit, bHit;
  logic [THRESH_W-1:0] aThreshQ, bThreshQ;

  tmo_control u_ctl (
    .clk(clk), .rstN(rstN), .periphEn(periphEn), .sclIn(sclIn), .sdaIn(sdaIn),
    .xferStart(xferStart), .xferStop(xferStop), .extWindow(extWindow),
    .detAEn(detAEn), .detBEn(detBEn), .detACfgWr(detACfgWr), .detBCfgWr(detBCfgWr),
    .flagClr(flagClr), .aIdleQ(aIdleQ), .aHit(aHit), .bHit(bHit),
    .strobe(strobe), .timeoutFlag(timeoutFlag), .timeoutPulse(timeoutPulse)
  );

  tmo_datapath #(
    .THRESH_W(THRESH_W), .LOW_SCALE(LOW_SCALE), .IDLE_SCALE(IDLE_SCALE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .aLimitIn(detALimit),
    .aIdleIn(detAIdleSel), .bLimitIn(detBLimit), .aIdleQ(aIdleQ),
    .aThreshQ(aThreshQ), .bThreshQ(bThreshQ), .aHit(aHit), .bHit(bHit)
  );

  assert_cfg_lock_a_R7: assert property (@(posedge clk) disable iff (!rstN)
    detAEn |=> ($stable(aThreshQ) && $stable(aIdleQ)));
  assert_cfg_lock_b_R7: assert property (@(posedge clk) disable iff (!rstN)
    detBEn |=> $stable(bThreshQ));
endmodule

// File: tb/tb_smbus_timeout_monitor.sv
`timescale 1ns/1ps
module tb_smbus_timeout_monitor;
  localparam int TW = 3;
  localparam int LS = 4;
  localparam int IS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic periphEn = 1'b0, sclIn = 1'b1, sdaIn = 1'b1, xferStart = 1'b0, xferStop = 1'b0;
  logic extWindow = 1'b0, detAEn = 1'b0, detAIdleSel = 1'b0, detACfgWr = 1'b0;
  logic detBEn = 1'b0, detBCfgWr = 1'b0, flagClr = 1'b0;
  logic [TW-1:0] detALimit = '0, detBLimit = '0;
  logic timeoutFlag, timeoutPulse;
  int checks = 0;
  int errors = 0;

  smbus_timeout_monitor #(.THRESH_W(TW), .LOW_SCALE(LS), .IDLE_SCALE(IS)) dut (
    .clk(clk), .rstN(rstN), .periphEn(periphEn), .sclIn(sclIn), .sdaIn(sdaIn),
    .xferStart(xferStart), .xferStop(xferStop), .extWindow(extWindow),
    .detAEn(detAEn), .detAIdleSel(detAIdleSel), .detALimit(detALimit),
    .detACfgWr(detACfgWr), .detBEn(detBEn), .detBLimit(detBLimit),
    .detBCfgWr(detBCfgWr), .flagClr(flagClr),
    .timeoutFlag(timeoutFlag), .timeoutPulse(timeoutPulse)
  );

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfgA(int t, bit idle);
    detAEn = 1'b0; tick();
    detALimit = TW'(t); detAIdleSel = idle; detACfgWr = 1'b1; tick();
    detACfgWr = 1'b0;
  endtask

  task automatic cfgB(int t);
    detBEn = 1'b0; tick();
    detBLimit = TW'(t); detBCfgWr = 1'b1; tick();
    detBCfgWr = 1'b0;
  endtask

  task automatic clrFlag();
    flagClr = 1'b1; tick(); flagClr = 1'b0;
  endtask

  task automatic waitFlag(output int n);
    n = -1;
    for (int i = 1; i <= 300; i++) begin
      tick();
      if (timeoutFlag) begin n = i; break; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int lows;
    int seen;
    @(negedge clk); tick(); tick();
    rstN = 1'b1; tick();
    chk("R1 flag", timeoutFlag, 0);
    chk("R1 pulse", timeoutPulse, 0);
    periphEn = 1'b1; tick();

    // R2 sweep of the clock-low mode
    for (int t = 0; t < 8; t++) begin
      sclIn = 1'b1; cfgA(t, 1'b0); detAEn = 1'b1; tick(); clrFlag();
      sclIn = 1'b0; waitFlag(n);
      chk("R2 trip cycle", n, LS * (t + 1));
      chk("R10 pulse on rise", timeoutPulse, 1);
      tick();
      chk("R10 pulse one cycle", timeoutPulse, 0);
      chk("R8 sticky", timeoutFlag, 1);
      sclIn = 1'b1; repeat (3) tick();
      chk("R8 sticky line high", timeoutFlag, 1);
      detAEn = 1'b0; clrFlag();
      chk("R8 cleared", timeoutFlag, 0);
    end

    // R2 restart on a single high cycle (L=16)
    cfgA(3, 1'b0); detAEn = 1'b1; tick(); clrFlag();
    sclIn = 1'b0; repeat (15) tick();
    sclIn = 1'b1; tick();
    sclIn = 1'b0; repeat (15) tick();
    chk("R2 restart no trip", timeoutFlag, 0);
    tick();
    chk("R2 restart trip", timeoutFlag, 1);
    sclIn = 1'b1; detAEn = 1'b0; clrFlag();

    // R3 sweep of the idle mode
    for (int t = 0; t < 8; t++) begin
      sclIn = 1'b0; cfgA(t, 1'b1); detAEn = 1'b1; tick(); clrFlag();
      sclIn = 1'b1; sdaIn = 1'b1; waitFlag(n);
      chk("R3 trip cycle", n, IS * (t + 1));
      sclIn = 1'b0; detAEn = 1'b0; clrFlag();
    end
    // R3 restart on a low SDA cycle (L=8)
    sclIn = 1'b0; cfgA(3, 1'b1); detAEn = 1'b1; tick(); clrFlag();
    sclIn = 1'b1; repeat (7) tick();
    sdaIn = 1'b0; tick();
    sdaIn = 1'b1; repeat (7) tick();
    chk("R3 restart no trip", timeoutFlag, 0);
    tick();
    chk("R3 restart trip", timeoutFlag, 1);
    sclIn = 1'b1; detAEn = 1'b0; clrFlag();

    // R4 sweep of detector B with gaps in SCL-low and in the window
    for (int t = 0; t < 8; t++) begin
      cfgB(t); detBEn = 1'b1; sclIn = 1'b1;
      xferStart = 1'b1; tick(); xferStart = 1'b0; clrFlag();
      lows = 0; seen = 0;
      for (int i = 0; i < 400 && seen == 0; i++) begin
        sclIn = ((i % 5) < 3) ? 1'b0 : 1'b1;
        extWindow = ((i % 7) != 6);
        tick();
        if (!sclIn && extWindow) lows++;
        if (timeoutFlag) seen = 1;
      end
      chk("R4 counted lows at trip", lows, LS * (t + 1));
      sclIn = 1'b1; detBEn = 1'b0; clrFlag();
    end

    // R5 STOP and START clear B (L=8)
    extWindow = 1'b1;
    for (int k = 0; k < 2; k++) begin
      cfgB(1); detBEn = 1'b1; tick(); clrFlag();
      sclIn = 1'b0; repeat (7) tick();
      sclIn = 1'b1;
      if (k == 0) xferStop = 1'b1; else xferStart = 1'b1;
      tick(); xferStop = 1'b0; xferStart = 1'b0;
      sclIn = 1'b0; repeat (7) tick();
      chk("R5 count cleared", timeoutFlag, 0);
      tick();
      chk("R5 trip after restart", timeoutFlag, 1);
      sclIn = 1'b1; detBEn = 1'b0; clrFlag();
    end
    extWindow = 1'b0;

    // R6 disabled detector and partial count discard (L=4)
    cfgA(0, 1'b0); sclIn = 1'b0; repeat (20) tick();
    chk("R6 disabled no trip", timeoutFlag, 0);
    detAEn = 1'b1; repeat (3) tick();
    detAEn = 1'b0; tick();
    detAEn = 1'b1; repeat (3) tick();
    chk("R6 count discarded", timeoutFlag, 0);
    tick();
    chk("R6 trip after re-enable", timeoutFlag, 1);
    sclIn = 1'b1; detAEn = 1'b0; clrFlag();

    // R7 writes while enabled are ignored (L=12 kept)
    cfgA(2, 1'b0); detAEn = 1'b1;
    detALimit = '0; detAIdleSel = 1'b1; detACfgWr = 1'b1; tick(); detACfgWr = 1'b0;
    clrFlag(); sclIn = 1'b0; waitFlag(n);
    chk("R7 A config locked", n, 12);
    sclIn = 1'b1; detAEn = 1'b0; clrFlag();
    cfgB(0); detBEn = 1'b1; extWindow = 1'b1;
    detBLimit = 3'd5; detBCfgWr = 1'b1; tick(); detBCfgWr = 1'b0;
    clrFlag(); sclIn = 1'b0; waitFlag(n);
    chk("R7 B config locked", n, 4);
    sclIn = 1'b1; detBEn = 1'b0; extWindow = 1'b0; clrFlag();

    // R8 trip wins over a clear in the same cycle (L=8)
    cfgA(1, 1'b0); detAEn = 1'b1; tick();
    flagClr = 1'b1; sclIn = 1'b0; waitFlag(n);
    chk("R8 set wins over clear", n, 8);
    tick();
    chk("R8 clear after trip", timeoutFlag, 0);
    flagClr = 1'b0; sclIn = 1'b1; detAEn = 1'b0; tick();

    // R11 long low episode trips once (L=4, counter max 63)
    cfgA(0, 1'b0); detAEn = 1'b1; tick();
    sclIn = 1'b0; waitFlag(n);
    chk("R11 first trip", n, 4);
    clrFlag();
    seen = 0;
    for (int i = 0; i < 150; i++) begin
      tick();
      if (timeoutFlag) seen++;
    end
    chk("R11 no second trip", seen, 0);
    sclIn = 1'b1; tick();

    // R10 no pulse when the flag is already set
    sclIn = 1'b0; waitFlag(n);
    sclIn = 1'b1; tick();
    sclIn = 1'b0; seen = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (timeoutPulse) seen++;
    end
    chk("R10 no pulse while set", seen, 0);
    chk("R10 flag held", timeoutFlag, 1);

    // R9 peripheral disable clears flag and count
    periphEn = 1'b0; tick();
    chk("R9 flag cleared", timeoutFlag, 0);
    periphEn = 1'b1; sclIn = 1'b1; tick();
    sclIn = 1'b0; repeat (3) tick();
    periphEn = 1'b0; tick();
    periphEn = 1'b1; repeat (3) tick();
    chk("R9 count cleared", timeoutFlag, 0);
    tick();
    chk("R9 trip after enable", timeoutFlag, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule